// File: doc/BRIEF.md
# Power Mode Controller with Missing-Clock Watch

This block governs the clocking state of a small 8-bit microcontroller core through a single special-function register placed on the core's register bus. Software writes the register to hold the serial rate-doubler setting and five scratch flags. It also writes two one-shot request bits that put the core to sleep. The block drives three registered enables: one gates the CPU clock, one gates the peripheral clock domain, and one switches the internal oscillator on or off.

There are two sleep levels. The light level halts only the CPU clock. Timers, interrupt logic, serial and analog peripherals keep their clock, and the light level ends as soon as any interrupt that is both pending and enabled appears. The deep level turns off the oscillator and every digital clock. Only a reset ends the deep level. The reset can come from outside, or from the built-in missing-clock watch. That watch counts ticks of an independent slow reference while the CPU clock is absent, and once its limit is reached it issues an internal reset. The request bits are never stored, so they always read as zero.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset, `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, `baud_dbl` and `rst_req` are 0, and reading the register returns 0x00.
- R2: Only bus address 0x87 is decoded. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R3: A write to the register stores bit 7 as the rate doubler, which drives `baud_dbl` from the clock edge that accepts the write. Bits 6..2 are stored as five free flags. Both read back in the same bit positions.
- R4: Read data appears on `sfr_rdata` one cycle after the read strobe, with bits 1..0 always 0, and shows the contents held before any write in that same cycle.
- R5: A write with bit 0 set while running enters the light sleep. From the accepting edge `cpu_clk_en` is 0, while `per_clk_en` and `osc_en` stay 1.
- R6: In light sleep, a cycle in which `irq_req & irq_en` is non-zero returns `cpu_clk_en` to 1 at the next edge. A pending interrupt that is masked has no effect.
- R7: A write with bit 1 set while running enters deep sleep, and all three enables go to 0 at the accepting edge. When bits 0 and 1 are both set, deep sleep wins.
- R8: Deep sleep is left only through reset. Interrupts and register writes do not release it, and the reset clears the register and restores the run-state enables.
- R9: With `mcd_en` at 1, each `ref_tick` cycle in which the CPU clock is gated advances a timeout counter. The MCD_TICKS-th such tick raises `rst_req` for exactly one cycle. The following edge resets the block to its run state with the register cleared.
- R10: With `mcd_en` at 0, or with the CPU clock running, `rst_req` never rises, however many reference ticks arrive.
- R11: Sleep requests are honoured only in the run state. A deep-sleep request written during light sleep leaves the enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, always running |
| rst | input | 1 | Synchronous active-high reset from the system reset source |
| sfr_addr | input | ADDR_W | Register bus address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_rd | input | 1 | Register read strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Registered read data, 0 when not addressed |
| irq_req | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| mcd_en | input | 1 | Missing-clock watch enable |
| ref_tick | input | 1 | One-cycle pulse from the slow reference timebase |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Internal oscillator enable |
| baud_dbl | output | 1 | Serial rate doubler |
| rst_req | output | 1 | One-cycle internal reset request from the missing-clock watch |

## Verification
A mode state machine in the wrong state shows at once on the three enables, on the edge after the request or wake. A lost or extra transition is therefore visible in the same cycle the bench samples. Corruption in the register store is hidden until the next read, one cycle after the strobe, so the bench reads after every write and every reset. An error in the timeout counter shows only when the limit is reached. The bench therefore checks just before the final tick that `rst_req` has not fired early, and checks exactly on that tick that it fires.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_STOP = 2'd2
  } pm_state_t;

  localparam int REG_W    = 8;
  localparam int BIT_LITE = 0;   // light sleep request
  localparam int BIT_DEEP = 1;   // deep sleep request
  localparam int BIT_DBL  = 7;   // rate doubler
  localparam int FLAG_LO  = 2;
  localparam int FLAG_W   = 5;
endpackage

// File: rtl/pwr_sfr_reg.sv
module pwr_sfr_reg
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              dbl,
  output logic              lite_req,
  output logic              deep_req
);
  logic              hit;
  logic              wr_hit;
  logic              rd_hit;
  logic [FLAG_W-1:0] flags;

  assign hit    = (addr == SFR_ADDR);
  assign wr_hit = wr && hit;
  assign rd_hit = rd && hit;

  // request bits become single-cycle pulses, never stored
  assign lite_req = wr_hit && wdata[BIT_LITE];
  assign deep_req = wr_hit && wdata[BIT_DEEP];

  always_ff @(posedge clk) begin
    if (rst) begin
      dbl   <= 1'b0;
      flags <= '0;
      rdata <= '0;
    end else begin
      if (wr_hit) begin
        dbl   <= wdata[BIT_DBL];
        flags <= wdata[FLAG_LO +: FLAG_W];
      end
      rdata <= rd_hit ? {dbl, flags, 2'b00} : '0;
    end
  end

  p_req_bits_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (rdata[1:0] == 2'b00));

  p_flags_stored_r3: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (flags == $past(wdata[FLAG_LO +: FLAG_W])) && (dbl == $past(wdata[BIT_DBL])));

  p_foreign_write_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && !hit) |=> ($stable(flags) && $stable(dbl)));
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lite_req,
  input  logic             deep_req,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en
);
  pm_state_t state, nxt;
  logic      wake;

  assign wake = |(irq_req & irq_en);

  always_comb begin
    nxt = state;
    unique case (state)
      PM_RUN:  if (deep_req) nxt = PM_STOP;
               else if (lite_req) nxt = PM_IDLE;
      PM_IDLE: if (wake) nxt = PM_RUN;
      PM_STOP: nxt = PM_STOP;
      default: nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PM_RUN;
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      osc_en     <= 1'b1;
    end else begin
      state      <= nxt;
      cpu_clk_en <= (nxt == PM_RUN);
      per_clk_en <= (nxt != PM_STOP);
      osc_en     <= (nxt != PM_STOP);
    end
  end

  p_deep_all_off_r7: assert property (@(posedge clk) disable iff (rst)
    (state == PM_RUN && deep_req) |=> (!cpu_clk_en && !per_clk_en && !osc_en));

  p_lite_keeps_periph_r5: assert property (@(posedge clk) disable iff (rst)
    (state == PM_RUN && lite_req && !deep_req) |=> (!cpu_clk_en && per_clk_en && osc_en));

  p_wake_restores_cpu_r6: assert property (@(posedge clk) disable iff (rst)
    (state == PM_IDLE && wake) |=> cpu_clk_en);

  p_deep_holds_r8: assert property (@(posedge clk) disable iff (rst)
    !osc_en |=> !osc_en);

  p_idle_ignores_requests_r11: assert property (@(posedge clk) disable iff (rst)
    (state == PM_IDLE && !wake) |=> (!cpu_clk_en && per_clk_en));
endmodule

// File: rtl/pwr_clk_watch.sv
module pwr_clk_watch #(
  parameter int MCD_TICKS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic mcd_en,
  input  logic ref_tick,
  input  logic cpu_clk_en,
  output logic fire
);
  localparam int CW = (MCD_TICKS > 1) ? $clog2(MCD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(MCD_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !mcd_en || cpu_clk_en) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (ref_tick) begin
        if (cnt == LAST) begin
          cnt  <= '0;
          fire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_fire_single_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

  p_fire_needs_enable_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(fire) |-> $past(mcd_en && ref_tick && !cpu_clk_en));
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SFR_ADDR = 8'h87,
  parameter int N_IRQ = 4,
  parameter int MCD_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic              sfr_rd,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic              mcd_en,
  input  logic              ref_tick,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              baud_dbl,
  output logic              rst_req
);
  logic core_rst;
  logic lite_req;
  logic deep_req;
  logic mcd_fire;

  // the watch's own reset request also clears this block
  assign core_rst = rst || mcd_fire;
  assign rst_req  = mcd_fire;

  pwr_sfr_reg #(.ADDR_W(ADDR_W), .SFR_ADDR(SFR_ADDR)) u_reg (
    .clk      (clk),
    .rst      (core_rst),
    .addr     (sfr_addr),
    .wr       (sfr_wr),
    .rd       (sfr_rd),
    .wdata    (sfr_wdata),
    .rdata    (sfr_rdata),
    .dbl      (baud_dbl),
    .lite_req (lite_req),
    .deep_req (deep_req)
  );

  pwr_mode_fsm #(.N_IRQ(N_IRQ)) u_fsm (
    .clk        (clk),
    .rst        (core_rst),
    .lite_req   (lite_req),
    .deep_req   (deep_req),
    .irq_req    (irq_req),
    .irq_en     (irq_en),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en)
  );

  pwr_clk_watch #(.MCD_TICKS(MCD_TICKS)) u_watch (
    .clk        (clk),
    .rst        (rst),
    .mcd_en     (mcd_en),
    .ref_tick   (ref_tick),
    .cpu_clk_en (cpu_clk_en),
    .fire       (mcd_fire)
  );

  p_cpu_implies_periph_r5: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> (per_clk_en && osc_en));

  p_watch_resets_block_r9: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> (cpu_clk_en && osc_en && !baud_dbl));
endmodule

// File: tb/pwr_mode_ctl_test.sv
module pwr_mode_ctl_test;
  localparam int MCD = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = 8'h00;
  logic       sfr_wr = 1'b0;
  logic       sfr_rd = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic [3:0] irq_req = 4'h0;
  logic [3:0] irq_en = 4'h0;
  logic       mcd_en = 1'b0;
  logic       ref_tick = 1'b0;
  logic       cpu_clk_en, per_clk_en, osc_en, baud_dbl, rst_req;

  pwr_mode_ctl #(.MCD_TICKS(MCD)) uut (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_req(irq_req), .irq_en(irq_en),
    .mcd_en(mcd_en), .ref_tick(ref_tick), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .baud_dbl(baud_dbl), .rst_req(rst_req)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         due;
    int         sel;   // 0: read data, 1: status {rst_req,osc,per,cpu,baud}
    logic [7:0] exp;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  function automatic void push(int due, int sel, logic [7:0] e, string req);
    exp_t it;
    it.due = due; it.sel = sel; it.exp = e; it.req = req;
    q.push_back(it);
  endfunction

  // monitor: pops expectations as they fall due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = (it.sel == 0) ? sfr_rdata
                          : {3'b000, rst_req, osc_en, per_clk_en, cpu_clk_en, baud_dbl};
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s: actual=%02h expected=%02h (cycle %0d)", it.req, act, it.exp, cyc);
      end
    end
  end

  task automatic wr_exp(input logic [7:0] a, input logic [7:0] d, input logic [4:0] st, input string req);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    push(cyc + 1, 1, {3'b000, st}, req);
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string req);
    sfr_addr = a; sfr_rd = 1'b1;
    push(cyc + 1, 0, e, req);
    @(negedge clk);
    sfr_rd = 1'b0;
  endtask

  task automatic st_exp(input logic [4:0] st, input string req);
    push(cyc + 1, 1, {3'b000, st}, req);
    @(negedge clk);
  endtask

  task automatic tick();
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic reset_pulse(input string req);
    rst = 1'b1;
    push(cyc + 1, 1, 8'b0000_1110, req);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    st_exp(5'b01110, "R1");
    rd_exp(8'h87, 8'h00, "R1");

    wr_exp(8'h87, 8'hFC, 5'b01111, "R3");
    rd_exp(8'h87, 8'hFC, "R3");
    wr_exp(8'h87, 8'hA8, 5'b01111, "R3");
    rd_exp(8'h87, 8'hA8, "R4");

    wr_exp(8'h86, 8'hFF, 5'b01111, "R2");
    rd_exp(8'h87, 8'hA8, "R2");
    rd_exp(8'h86, 8'h00, "R2");

    wr_exp(8'h87, 8'hA9, 5'b01101, "R5");
    rd_exp(8'h87, 8'hA8, "R4");

    irq_req = 4'b0001; irq_en = 4'b1110;
    st_exp(5'b01101, "R6");
    st_exp(5'b01101, "R6");
    irq_req = 4'b0000;
    wr_exp(8'h87, 8'hAA, 5'b01101, "R11");
    rd_exp(8'h87, 8'hA8, "R11");

    irq_req = 4'b0010; irq_en = 4'b0010;
    push(cyc + 1, 1, 8'b0000_1111, "R6");
    @(negedge clk);
    irq_req = 4'b0000; irq_en = 4'b0000;

    wr_exp(8'h87, 8'h03, 5'b00000, "R7");
    rd_exp(8'h87, 8'h00, "R8");
    irq_req = 4'b1111; irq_en = 4'b1111;
    st_exp(5'b00000, "R8");
    st_exp(5'b00000, "R8");
    irq_req = 4'b0000; irq_en = 4'b0000;
    wr_exp(8'h87, 8'h01, 5'b00000, "R8");
    reset_pulse("R8");
    rd_exp(8'h87, 8'h00, "R8");

    mcd_en = 1'b1;
    wr_exp(8'h87, 8'h82, 5'b00001, "R7");
    for (int i = 0; i < MCD - 1; i++) tick();
    st_exp(5'b00001, "R9");
    ref_tick = 1'b1;
    push(cyc + 1, 1, 8'b0001_0001, "R9");
    @(negedge clk);
    ref_tick = 1'b0;
    push(cyc + 1, 1, 8'b0000_1110, "R9");
    @(negedge clk);
    rd_exp(8'h87, 8'h00, "R9");

    mcd_en = 1'b0;
    wr_exp(8'h87, 8'h82, 5'b00001, "R7");
    for (int i = 0; i < MCD + 2; i++) tick();
    st_exp(5'b00001, "R10");
    reset_pulse("R10");
    mcd_en = 1'b1;
    for (int i = 0; i < MCD + 2; i++) tick();
    st_exp(5'b01110, "R10");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule